// File: doc/BRIEF.md
# Autonegotiation Result Validator Sequencer

This block is a bus initiator that manages an Ethernet link PHY through a simple register access bus. After reset it programs the PHY's fractional PLL. The PLL registers sit in a hidden register bank, and the block reaches them through the PHY's indirect test-control window. It then polls the MII status register without pause.

The block does not trust the completion flag of autonegotiation. When negotiation is enabled and the flag shows complete, the block reads a hidden-bank status bit and the partner ability and expansion registers. If these disagree with the flag, it writes a restart to the MII control register. It then waits for the flag to drop and rise again, and validates once more. The outputs are a link-valid level, a sticky failure flag and the number of restarts issued in the current run of failed validations.

Bus protocol: the block raises `regReq` and holds the command fields until the PHY side answers with a one-cycle `regAck`. On that cycle `regRdata` carries the read data and `regErr` marks a failed access.

Top module: `aneg_guard`

## Requirements
- R1: While `rstN` is low, `regReq`, `linkValid`, `failFlag` and `retryCount` are all 0.
- R2: Once `regReq` rises, it stays high with `regWrite`, `regAddr` and `regWdata` unchanged until the cycle in which `regAck` is sampled high. It then drops, so each acknowledge completes exactly one access.
- R3: After reset the block issues 21 writes: three hidden writes to bank 3. The targets and values, in order, are register 0x1B = 0x0005, register 0x1D = 0x029A and register 0x1C = 0xAAAA. Each hidden write is: data to register 23, then register 20 = 0x4000 | 3<<11 | 0x0400 | reg.
- R4: Every hidden access starts by writing register 20 with 0x0000, 0x0400, 0x0000, 0x0400 and ends by writing register 20 with 0x0000. An access answered with `regErr` skips straight to that closing write, and the block then returns to polling.
- R5: The block repeatedly reads register 1, the status register. With `anegEnable` low, `linkValid` follows status bit 2 and no hidden access is made.
- R6: With `anegEnable` high, status bit 5 (complete) set and no validation yet, the block does a hidden read: it writes register 20 = 0x8D80 (read, bank 1, register 0xC) and reads register 21. It then reads register 5 (partner ability) and register 6 (expansion).
- R7: The result is valid when hidden bit 12 is set, unless expansion bit 0 is set and partner-ability bit 14 is clear. A valid result sets `linkValid` and clears `retryCount`.
- R8: When hidden bit 12 is clear, `linkValid` stays low, `retryCount` increments, and register 0 is written with 0x1200 (restart at bit 9).
- R9: When expansion bit 0 is set and partner-ability bit 14 is clear (for example partner ability 0x0001), the block restarts. When expansion bit 0 is clear, the partner-ability value does not affect the verdict.
- R10: After a restart the block does not validate again until status bit 5 has read 0 and then 1.
- R11: Up to 6 restarts are issued in a row. A failed validation with `retryCount` at 6 sets `failFlag`, keeps `linkValid` low and stops all bus activity. Only reset clears `failFlag`.
- R12: When status bit 5 reads 0, `linkValid` drops. The next completion is validated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| anegEnable | input | 1 | Autonegotiation is enabled; validation runs only when high |
| regReq | output | 1 | Register access request, held until acknowledged |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 5 | PHY register number |
| regWdata | output | 16 | Write data |
| regAck | input | 1 | One-cycle access acknowledge |
| regErr | input | 1 | Access failed, valid with `regAck` |
| regRdata | input | 16 | Read data, valid with `regAck` |
| linkValid | output | 1 | Negotiated result checked and trusted, or link up when negotiation is off |
| failFlag | output | 1 | Sticky: the retry limit was exhausted |
| retryCount | output | 3 | Restarts issued since the last good validation |

## Verification
The hardest state to reach is the one right after a restart. The partner model has to keep reporting completion, so that the block's wait for a falling edge of bit 5 is what holds validation back. The bench's PHY model therefore has two modes. In one, a restart write hides completion for two status reads. In the other, completion never drops, and the bench counts hidden read commands to show that no second validation starts. The retry limit is reached by leaving bad hidden-bank data in place, so that every recompletion fails again. Error injection is tied to the hidden read command itself, so the closing write can be checked right after the access that failed.

// File: rtl/aneg_guard_pkg.sv
package aneg_guard_pkg;

  // PHY register numbers (decoded by the PHY, so fixed)
  localparam logic [4:0] MII_CTRL = 5'd0;
  localparam logic [4:0] MII_STAT = 5'd1;
  localparam logic [4:0] MII_LPA  = 5'd5;
  localparam logic [4:0] MII_EXP  = 5'd6;
  localparam logic [4:0] TST_CTL  = 5'd20;
  localparam logic [4:0] TST_RD   = 5'd21;
  localparam logic [4:0] TST_WR   = 5'd23;

  // bit positions inside PHY registers
  localparam int CTL_RD_BIT    = 15;
  localparam int CTL_WR_BIT    = 14;
  localparam int CTL_BANK_LSB  = 11;
  localparam int CTL_MODE_BIT  = 10;
  localparam int CTL_RADR_LSB  = 5;
  localparam logic [3:0] STAT_CPL_BIT  = 4'd5;
  localparam logic [3:0] STAT_LINK_BIT = 4'd2;
  localparam logic [3:0] LPA_ACK_BIT   = 4'd14;
  localparam logic [3:0] EXP_ABLE_BIT  = 4'd0;
  localparam logic [3:0] HID_GOOD_BIT  = 4'd12;

  localparam logic [15:0] RESTART_CMD = 16'h1200;

  localparam logic [1:0] PLL_BANK = 2'd3;
  localparam logic [1:0] CHK_BANK = 2'd1;
  localparam logic [4:0] CHK_REG  = 5'h0C;
  localparam logic [1:0] INIT_LAST = 2'd2;
  localparam logic [2:0] STEP_CLOSE = 3'd6;

  typedef enum logic [3:0] {
    PH_INIT, PH_POLL, PH_POLLCHK, PH_HIDRD, PH_LPA, PH_EXP,
    PH_DECIDE, PH_RESTART, PH_HALT
  } phase_t;

  typedef enum logic [2:0] {
    CAP_NONE, CAP_STAT, CAP_HID, CAP_LPA, CAP_EXP
  } cap_t;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [15:0] wdata;
    cap_t        cap;
  } acc_t;

  typedef struct packed {
    logic        issue;
    logic        wr;
    logic [4:0]  addr;
    logic [15:0] wdata;
    cap_t        capSel;
    logic [3:0]  bitA;
    logic [3:0]  bitB;
    logic        incRetry;
    logic        clrRetry;
    logic        setLink;
    logic        clrLink;
    logic        setFail;
  } strobe_t;

  function automatic logic [15:0] ctlWord(input logic rd, input logic [1:0] bank,
                                          input logic [4:0] regNum);
    logic [15:0] w;
    w = '0;
    w[CTL_MODE_BIT] = 1'b1;
    w[CTL_BANK_LSB +: 2] = bank;
    if (rd) begin
      w[CTL_RD_BIT] = 1'b1;
      w[CTL_RADR_LSB +: 5] = regNum;
    end else begin
      w[CTL_WR_BIT] = 1'b1;
      w[4:0] = regNum;
    end
    return w;
  endfunction

  // one step of a wrapped hidden-bank access: unlock x4, command/data x2, close
  function automatic acc_t hidStep(input logic [2:0] step, input logic isRead,
                                   input logic [1:0] bank, input logic [4:0] regNum,
                                   input logic [15:0] val);
    acc_t a;
    a.wr = 1'b1; a.addr = TST_CTL; a.wdata = '0; a.cap = CAP_NONE;
    case (step)
      3'd0, 3'd2: a.wdata = 16'h0000;
      3'd1, 3'd3: a.wdata = 16'h0400;
      3'd4: begin
        if (isRead) a.wdata = ctlWord(1'b1, bank, regNum);
        else begin a.addr = TST_WR; a.wdata = val; end
      end
      3'd5: begin
        if (isRead) begin a.wr = 1'b0; a.addr = TST_RD; a.cap = CAP_HID; end
        else a.wdata = ctlWord(1'b0, bank, regNum);
      end
      default: a.wdata = 16'h0000;
    endcase
    return a;
  endfunction

  function automatic logic [4:0] initReg(input logic [1:0] idx);
    case (idx)
      2'd0: return 5'h1B;
      2'd1: return 5'h1D;
      default: return 5'h1C;
    endcase
  endfunction

  function automatic logic [15:0] initVal(input logic [1:0] idx);
    case (idx)
      2'd0: return 16'h0005;
      2'd1: return 16'h029A;
      default: return 16'hAAAA;
    endcase
  endfunction

endpackage

// File: rtl/aneg_guard_dp.sv
module aneg_guard_dp
  import aneg_guard_pkg::*;
#(
  parameter int MAX_RETRY = 6,
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic               regAck,
  input  logic               regErr,
  input  logic [15:0]        regRdata,
  output logic               regReq,
  output logic               regWrite,
  output logic [4:0]         regAddr,
  output logic [15:0]        regWdata,
  output logic               accDone,
  output logic               accErr,
  output logic               statCpl,
  output logic               statLink,
  output logic               verdictOk,
  output logic               retryAtMax,
  output logic               linkValid,
  output logic               failFlag,
  output logic [RETRY_W-1:0] retryCount
);

  localparam logic [RETRY_W-1:0] RETRY_MAX = RETRY_W'(MAX_RETRY);

  logic hidGood, lpaAck, expAble;
  logic bitA, bitB, capOk;

  assign accDone = regReq & regAck;
  assign accErr  = accDone & regErr;
  assign capOk   = accDone & ~regErr;
  assign bitA    = regRdata[st.bitA];
  assign bitB    = regRdata[st.bitB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regReq   <= 1'b0;
      regWrite <= 1'b0;
      regAddr  <= '0;
      regWdata <= '0;
    end else if (st.issue) begin
      regReq   <= 1'b1;
      regWrite <= st.wr;
      regAddr  <= st.addr;
      regWdata <= st.wdata;
    end else if (accDone) begin
      regReq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statCpl  <= 1'b0;
      statLink <= 1'b0;
      hidGood  <= 1'b0;
      lpaAck   <= 1'b0;
      expAble  <= 1'b0;
    end else if (capOk) begin
      case (st.capSel)
        CAP_STAT: begin statCpl <= bitA; statLink <= bitB; end
        CAP_HID:  hidGood <= bitA;
        CAP_LPA:  lpaAck  <= bitA;
        CAP_EXP:  expAble <= bitA;
        default: ;
      endcase
    end
  end

  assign verdictOk  = hidGood & ~(expAble & ~lpaAck);
  assign retryAtMax = (retryCount == RETRY_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retryCount <= '0;
      linkValid  <= 1'b0;
      failFlag   <= 1'b0;
    end else begin
      if (st.clrRetry) retryCount <= '0;
      else if (st.incRetry) retryCount <= retryCount + 1'b1;
      if (st.setLink) linkValid <= 1'b1;
      else if (st.clrLink) linkValid <= 1'b0;
      if (st.setFail) failFlag <= 1'b1;
    end
  end

  // R2
  reqHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWdata) && $stable(regWrite));
  // R2
  oneAck_chk: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> !regReq);
  // R11
  failSticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> failFlag);
  // R11
  failQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> !regReq && !st.issue && !linkValid);
  // R11
  retryBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.incRetry |-> !retryAtMax);

endmodule

// File: rtl/aneg_guard_ctrl.sv
module aneg_guard_ctrl
  import aneg_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    anegEnable,
  input  logic    accDone,
  input  logic    accErr,
  input  logic    statCpl,
  input  logic    statLink,
  input  logic    verdictOk,
  input  logic    retryAtMax,
  output strobe_t st
);

  phase_t     phase;
  logic [2:0] step;
  logic [1:0] initIdx;
  logic       launched, hidErr, waitDrop, validated;
  logic       accessPhase;
  acc_t       cur;

  always_comb begin
    st          = '0;
    accessPhase = 1'b0;
    cur         = '{wr: 1'b0, addr: 5'd0, wdata: 16'd0, cap: CAP_NONE};
    case (phase)
      PH_INIT: begin
        accessPhase = 1'b1;
        cur = hidStep(step, 1'b0, PLL_BANK, initReg(initIdx), initVal(initIdx));
      end
      PH_HIDRD: begin
        accessPhase = 1'b1;
        cur = hidStep(step, 1'b1, CHK_BANK, CHK_REG, 16'h0000);
        st.bitA = HID_GOOD_BIT;
      end
      PH_POLL: begin
        accessPhase = 1'b1;
        cur = '{wr: 1'b0, addr: MII_STAT, wdata: 16'd0, cap: CAP_STAT};
        st.bitA = STAT_CPL_BIT;
        st.bitB = STAT_LINK_BIT;
      end
      PH_LPA: begin
        accessPhase = 1'b1;
        cur = '{wr: 1'b0, addr: MII_LPA, wdata: 16'd0, cap: CAP_LPA};
        st.bitA = LPA_ACK_BIT;
      end
      PH_EXP: begin
        accessPhase = 1'b1;
        cur = '{wr: 1'b0, addr: MII_EXP, wdata: 16'd0, cap: CAP_EXP};
        st.bitA = EXP_ABLE_BIT;
      end
      PH_RESTART: begin
        accessPhase = 1'b1;
        cur = '{wr: 1'b1, addr: MII_CTRL, wdata: RESTART_CMD, cap: CAP_NONE};
      end
      PH_POLLCHK: begin
        if (!anegEnable) begin
          st.setLink = statLink;
          st.clrLink = ~statLink;
        end else if (waitDrop || !statCpl || !validated) begin
          st.clrLink = 1'b1;
        end
      end
      PH_DECIDE: begin
        if (verdictOk) begin
          st.setLink  = 1'b1;
          st.clrRetry = 1'b1;
        end else if (retryAtMax) begin
          st.setFail = 1'b1;
          st.clrLink = 1'b1;
        end else begin
          st.incRetry = 1'b1;
          st.clrLink  = 1'b1;
        end
      end
      default: ;
    endcase
    st.issue  = accessPhase & ~launched;
    st.wr     = cur.wr;
    st.addr   = cur.addr;
    st.wdata  = cur.wdata;
    st.capSel = cur.cap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_INIT;
      step      <= '0;
      initIdx   <= '0;
      launched  <= 1'b0;
      hidErr    <= 1'b0;
      waitDrop  <= 1'b0;
      validated <= 1'b0;
    end else begin
      if (st.issue) launched <= 1'b1;
      if (accDone) launched <= 1'b0;
      case (phase)
        PH_INIT, PH_HIDRD: if (accDone) begin
          if (accErr) hidErr <= 1'b1;
          if (step == STEP_CLOSE) begin
            step   <= '0;
            hidErr <= 1'b0;
            if (phase == PH_INIT) begin
              if (initIdx == INIT_LAST) phase <= PH_POLL;
              else initIdx <= initIdx + 1'b1;
            end else begin
              phase <= (hidErr || accErr) ? PH_POLL : PH_LPA;
            end
          end else begin
            step <= accErr ? STEP_CLOSE : step + 1'b1;
          end
        end
        PH_POLL: if (accDone) phase <= accErr ? PH_POLL : PH_POLLCHK;
        PH_POLLCHK: begin
          phase <= PH_POLL;
          if (!anegEnable) begin
            waitDrop  <= 1'b0;
            validated <= 1'b0;
          end else if (waitDrop) begin
            if (!statCpl) waitDrop <= 1'b0;
          end else if (!statCpl) begin
            validated <= 1'b0;
          end else if (!validated) begin
            phase <= PH_HIDRD;
          end
        end
        PH_LPA: if (accDone) phase <= accErr ? PH_POLL : PH_EXP;
        PH_EXP: if (accDone) phase <= accErr ? PH_POLL : PH_DECIDE;
        PH_DECIDE: begin
          if (verdictOk) begin
            validated <= 1'b1;
            phase     <= PH_POLL;
          end else if (retryAtMax) begin
            phase <= PH_HALT;
          end else begin
            phase <= PH_RESTART;
          end
        end
        PH_RESTART: if (accDone) begin
          if (!accErr) waitDrop <= 1'b1;
          phase <= PH_POLL;
        end
        default: phase <= PH_HALT;
      endcase
    end
  end

  // R10
  holdAfterRestart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_POLLCHK) && waitDrop |=> phase == PH_POLL);
  // R4
  errToClose_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIDRD) && accErr && (step != STEP_CLOSE) |=> step == STEP_CLOSE);
  // R6
  validateOnlyEnabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_POLLCHK) && !anegEnable |=> phase == PH_POLL);

endmodule

// File: rtl/aneg_guard.sv
module aneg_guard
  import aneg_guard_pkg::*;
#(
  parameter int MAX_RETRY = 6,
  localparam int RETRY_W = $clog2(MAX_RETRY + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               anegEnable,
  output logic               regReq,
  output logic               regWrite,
  output logic [4:0]         regAddr,
  output logic [15:0]        regWdata,
  input  logic               regAck,
  input  logic               regErr,
  input  logic [15:0]        regRdata,
  output logic               linkValid,
  output logic               failFlag,
  output logic [RETRY_W-1:0] retryCount
);

  strobe_t st;
  logic accDone, accErr, statCpl, statLink, verdictOk, retryAtMax;

  aneg_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anegEnable(anegEnable),
    .accDone(accDone), .accErr(accErr), .statCpl(statCpl), .statLink(statLink),
    .verdictOk(verdictOk), .retryAtMax(retryAtMax), .st(st)
  );

  aneg_guard_dp #(.MAX_RETRY(MAX_RETRY), .RETRY_W(RETRY_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .regAck(regAck), .regErr(regErr), .regRdata(regRdata),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .accDone(accDone), .accErr(accErr), .statCpl(statCpl), .statLink(statLink),
    .verdictOk(verdictOk), .retryAtMax(retryAtMax),
    .linkValid(linkValid), .failFlag(failFlag), .retryCount(retryCount)
  );

endmodule

// File: tb/aneg_guard_tb.sv
module aneg_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 4096;

  logic clk = 1'b0, rstN = 1'b0, anegEnable = 1'b0;
  logic regReq, regWrite, regAck = 1'b0, regErr = 1'b0;
  logic [4:0] regAddr;
  logic [15:0] regWdata, regRdata = '0;
  logic linkValid, failFlag;
  logic [2:0] retryCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  aneg_guard u_dut (
    .clk(clk), .rstN(rstN), .anegEnable(anegEnable),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regErr(regErr), .regRdata(regRdata),
    .linkValid(linkValid), .failFlag(failFlag), .retryCount(retryCount)
  );

  // PHY model state
  logic cpl = 0, lnk = 0, noDrop = 0, errOnCmd = 0;
  logic [15:0] hidVal = 0, lpaVal = 0, expVal = 0, lastCtl = 0;
  int dropReads = 0, accIdx = 0, restarts = 0, hidCmdCnt = 0, protoErr = 0;
  logic        logWr   [LOG_N];
  logic [4:0]  logAddr [LOG_N];
  logic [15:0] logData [LOG_N];
  int nChk = 0, nErr = 0;

  // responder: acts at falling edges only
  initial begin
    forever begin
      @(negedge clk);
      if (regReq) begin
        logic sWr; logic [4:0] sA; logic [15:0] sD; logic [15:0] rd; logic e;
        sWr = regWrite; sA = regAddr; sD = regWdata; rd = 16'h0; e = 1'b0;
        for (int k = 0; k < accIdx % 3; k++) begin
          @(negedge clk);
          if (!regReq || regWrite != sWr || regAddr != sA || regWdata != sD) protoErr++;
        end
        if (sWr) begin
          if (sA == 5'd20) begin
            lastCtl = sD;
            if (sD == 16'h8D80) begin
              hidCmdCnt++;
              if (errOnCmd) begin e = 1'b1; errOnCmd = 0; end
            end
          end
          if (sA == 5'd0 && sD[9]) begin restarts++; dropReads = noDrop ? 0 : 2; end
        end else begin
          case (sA)
            5'd1: begin
              rd[5] = (dropReads > 0) ? 1'b0 : cpl;
              rd[2] = lnk;
              if (dropReads > 0) dropReads--;
            end
            5'd5: rd = lpaVal;
            5'd6: rd = expVal;
            5'd21: rd = (lastCtl == 16'h8D80) ? hidVal : 16'h0000;
            default: rd = 16'hFFFF;
          endcase
        end
        if (accIdx < LOG_N) begin
          logWr[accIdx] = sWr; logAddr[accIdx] = sA; logData[accIdx] = sD;
        end
        accIdx++;
        regRdata = rd; regErr = e; regAck = 1'b1;
        @(negedge clk);
        regAck = 1'b0; regErr = 1'b0;
      end
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkLog(input string tag, input int idx, input logic wr, input int a, input int d);
    if (idx >= LOG_N) chkEq({tag, " log index"}, idx, 0);
    else begin
      chkEq({tag, " dir"}, int'(logWr[idx]), int'(wr));
      chkEq({tag, " addr"}, int'(logAddr[idx]), a);
      if (wr) chkEq({tag, " data"}, int'(logData[idx]), d);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRestart(input int base);
    for (int n = 0; n < 2000 && restarts <= base; n++) @(negedge clk);
  endtask

  function automatic int findCmd(input int from);
    for (int j = from; j < accIdx && j < LOG_N; j++)
      if (logWr[j] && logAddr[j] == 5'd20 && logData[j] == 16'h8D80) return j;
    return -1;
  endfunction

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  typedef struct packed { logic [15:0] hid, lpa, exp; logic ok; } vec_t;
  localparam vec_t VECS [6] = '{
    '{16'h1000, 16'h45E1, 16'h0001, 1'b1},   // R7 good
    '{16'h0000, 16'h45E1, 16'h0001, 1'b0},   // R8 hidden bit clear
    '{16'h1000, 16'h0001, 16'h0001, 1'b0},   // R9 early failure pattern
    '{16'h1000, 16'h0001, 16'h0000, 1'b1},   // R9 partner not able, lpa ignored
    '{16'hEFFF, 16'hC5E1, 16'h0000, 1'b0},   // R8 only bit 12 missing
    '{16'h1000, 16'h4000, 16'h0003, 1'b1}    // R7 ack present
  };

  initial begin
    logic [4:0] iReg [3];
    logic [15:0] iVal [3];
    iReg = '{5'h1B, 5'h1D, 5'h1C};
    iVal = '{16'h0005, 16'h029A, 16'hAAAA};
    // R1 reset state
    cyc(3);
    chkEq("R1 regReq", int'(regReq), 0);
    chkEq("R1 linkValid", int'(linkValid), 0);
    chkEq("R1 failFlag", int'(failFlag), 0);
    chkEq("R1 retryCount", int'(retryCount), 0);
    rstN = 1'b1;

    // R3 / R4 init programming sequence
    for (int n = 0; n < 1000 && accIdx < 21; n++) @(negedge clk);
    for (int i = 0; i < 21; i++) begin
      int s; int op;
      s = i % 7; op = i / 7;
      if (s < 4) chkLog("R4 unlock", i, 1'b1, 20, (s % 2) ? 16'h0400 : 16'h0000);
      else if (s == 4) chkLog("R3 data", i, 1'b1, 23, iVal[op]);
      else if (s == 5) chkLog("R3 cmd", i, 1'b1, 20, 16'h5C00 | iReg[op]);
      else chkLog("R4 close", i, 1'b1, 20, 0);
    end
    cyc(10);
    chkLog("R5 poll", 21, 1'b0, 1, 0);

    // R5 negotiation disabled: link follows status bit 2
    begin
      int h0;
      h0 = hidCmdCnt;
      lnk = 1; cpl = 1; cyc(60);
      chkEq("R5 link up", int'(linkValid), 1);
      chkEq("R5 no hidden access", hidCmdCnt, h0);
      lnk = 0; cpl = 0; cyc(60);
      chkEq("R5 link down", int'(linkValid), 0);
    end
    anegEnable = 1'b1;
    cyc(20);

    // vector table: R6 R7 R8 R9 R12
    for (int v = 0; v < 6; v++) begin
      int r0, h0, s0;
      hidVal = VECS[v].hid; lpaVal = VECS[v].lpa; expVal = VECS[v].exp;
      r0 = restarts; h0 = hidCmdCnt; s0 = accIdx;
      cpl = 1;
      if (VECS[v].ok) begin
        cyc(150);
        chkEq($sformatf("R7 v%0d link", v), int'(linkValid), 1);
        chkEq($sformatf("R7 v%0d retry", v), int'(retryCount), 0);
        chkEq($sformatf("R9 v%0d no restart", v), restarts, r0);
        chkEq($sformatf("R12 v%0d one validation", v), hidCmdCnt - h0, 1);
      end else begin
        waitRestart(r0);
        chkEq($sformatf("R8 v%0d restart", v), restarts, r0 + 1);
        chkEq($sformatf("R8 v%0d retry", v), int'(retryCount), 1);
        chkEq($sformatf("R8 v%0d link low", v), int'(linkValid), 0);
        hidVal = 16'h1000; lpaVal = 16'h45E1; expVal = 16'h0001;
        cyc(150);
        chkEq($sformatf("R7 v%0d recovered", v), int'(linkValid), 1);
        chkEq($sformatf("R7 v%0d retry cleared", v), int'(retryCount), 0);
        chkEq($sformatf("R10 v%0d two validations", v), hidCmdCnt - h0, 2);
      end
      if (v == 0) begin
        int j;
        j = findCmd(s0) - 4;
        chkLog("R6 open0", j, 1'b1, 20, 16'h0000);
        chkLog("R6 open1", j + 1, 1'b1, 20, 16'h0400);
        chkLog("R6 open2", j + 2, 1'b1, 20, 16'h0000);
        chkLog("R6 open3", j + 3, 1'b1, 20, 16'h0400);
        chkLog("R6 cmd", j + 4, 1'b1, 20, 16'h8D80);
        chkLog("R6 read", j + 5, 1'b0, 21, 0);
        chkLog("R6 close", j + 6, 1'b1, 20, 16'h0000);
        chkLog("R6 lpa", j + 7, 1'b0, 5, 0);
        chkLog("R6 exp", j + 8, 1'b0, 6, 0);
      end
      cpl = 0; cyc(60);
      chkEq($sformatf("R12 v%0d link drop", v), int'(linkValid), 0);
    end

    // R10 completion never drops after restart: no revalidation
    begin
      int r0, h0;
      noDrop = 1; hidVal = 16'h0000; r0 = restarts; h0 = hidCmdCnt;
      cpl = 1;
      waitRestart(r0);
      cyc(200);
      chkEq("R10 held off", hidCmdCnt - h0, 1);
      chkEq("R10 retry", int'(retryCount), 1);
      hidVal = 16'h1000; cpl = 0; cyc(40); cpl = 1; cyc(150);
      chkEq("R10 revalidated", hidCmdCnt - h0, 2);
      chkEq("R10 link", int'(linkValid), 1);
      noDrop = 0; cpl = 0; cyc(60);
    end

    // R4 error on hidden read command goes straight to close
    begin
      int h0, s0, j;
      h0 = hidCmdCnt; s0 = accIdx; errOnCmd = 1;
      cpl = 1; cyc(200);
      j = findCmd(s0);
      chkLog("R4 err close", j + 1, 1'b1, 20, 16'h0000);
      chkLog("R4 err back to poll", j + 2, 1'b0, 1, 0);
      chkEq("R4 retried validation", hidCmdCnt - h0, 2);
      chkEq("R4 link", int'(linkValid), 1);
      cpl = 0; cyc(60);
    end

    // R11 retry limit
    begin
      int r0, a0;
      hidVal = 16'h0000; r0 = restarts;
      cpl = 1;
      for (int n = 0; n < 5000 && !failFlag; n++) @(negedge clk);
      cyc(5);
      chkEq("R11 restarts", restarts - r0, 6);
      chkEq("R11 fail", int'(failFlag), 1);
      chkEq("R11 link", int'(linkValid), 0);
      chkEq("R11 retry", int'(retryCount), 6);
      a0 = accIdx; hidVal = 16'h1000; cyc(100);
      chkEq("R11 bus quiet", accIdx, a0);
      chkEq("R11 sticky", int'(failFlag), 1);
    end

    // R1 reset again clears everything
    rstN = 1'b0; cyc(2);
    chkEq("R1 re-reset fail", int'(failFlag), 0);
    chkEq("R1 re-reset retry", int'(retryCount), 0);
    chkEq("R1 re-reset req", int'(regReq), 0);
    rstN = 1'b1; cyc(50);
    // R2 handshake
    chkEq("R2 protocol violations", protoErr, 0);
    summary();
  end

endmodule